// File: doc/BRIEF.md
# Torus Dimension-Order Wormhole Router

This block is one node of a two-dimensional torus network. Every ring link between neighbours is unidirectional, so each node has a single X input and a single X output, and the same for Y. It also has a local inject port and a local eject port. Packets are made of 16-bit flits. A head flit names the destination, body flits carry data, and a tail flit closes the packet. The route is fixed by the destination: the X offset is consumed first, then Y, and the packet is ejected when both coordinates match the node's own.

Each ring link carries two virtual channels, and each channel has its own valid and ready. A packet starts on channel 0. It moves to channel 1 when it takes the wrap-around hop of a ring, and it drops back to channel 0 when it turns from X into Y. This breaks the cyclic channel dependency that wrap-around rings would otherwise create. Every input virtual channel has a small flit FIFO. A head flit claims an output virtual channel, which stays reserved until the packet's tail leaves. Each physical output moves at most one flit per cycle, and a round-robin arbiter chooses among the inputs that want it.

The node coordinates come in on strap inputs, so one design serves every position in the array.

Top module: `torus_router`

## Requirements
- R1: A head flit whose destination x (flit bits [2*CW-1:CW]) and destination y (bits [CW-1:0]) both equal the node coordinates leaves on the eject port. No head flit with any other destination appears there.
- R2: A head flit whose destination x differs from the node x leaves on the X output, whatever its y.
- R3: A head flit whose destination x matches and whose destination y differs leaves on the Y output.
- R4: Virtual channel choice on the X output:
  - From the inject port, channel 0 is used.
  - From the X input, the channel the flit arrived on is kept.
  - When the node x is NX-1 (the wrap hop), channel 1 is forced in every case.
- R5: Virtual channel choice on the Y output:
  - From the inject port or the X input (a turn), channel 0 is used.
  - From the Y input, the arrival channel is kept.
  - When the node y is NY-1, channel 1 is forced in every case.
- R6: Flit kinds are encoded in bits 15 and 14: 01 is a head, 00 a body, 10 a tail, and 11 a single-flit packet.
  - Once a head of kind 01 is sent on an output virtual channel, no other head appears on that channel until the tail (kind 10) of the same packet has been sent.
  - Flits of a blocked packet wait in their FIFO.
- R7: When several input channels compete for one physical output, a round-robin arbiter chooses among them. Each physical output carries exactly one flit per cycle while requests remain, so every contender is served.
- R8: An output virtual channel is never shown valid while its ready is low. Flits wait until ready rises.
- R9: Each input virtual channel holds DEPTH flits in arrival order. Its ready is low when the FIFO is full, and a flit offered while ready is low is dropped.
- R10: During and right after reset, no output is valid and every input ready is high.
- R11: At most one virtual channel of a physical output is valid in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| node_x | input | CW | X coordinate of this node |
| node_y | input | CW | Y coordinate of this node |
| xin_valid | input | 2 | Per-channel valid, incoming X link |
| xin_data | input | 16 | Flit, incoming X link |
| xin_ready | output | 2 | Per-channel ready, incoming X link |
| yin_valid | input | 2 | Per-channel valid, incoming Y link |
| yin_data | input | 16 | Flit, incoming Y link |
| yin_ready | output | 2 | Per-channel ready, incoming Y link |
| inj_valid | input | 1 | Local inject valid |
| inj_data | input | 16 | Local inject flit |
| inj_ready | output | 1 | Local inject ready |
| xout_valid | output | 2 | Per-channel valid, outgoing X link |
| xout_data | output | 16 | Flit, outgoing X link |
| xout_ready | input | 2 | Per-channel ready, outgoing X link |
| yout_valid | output | 2 | Per-channel valid, outgoing Y link |
| yout_data | output | 16 | Flit, outgoing Y link |
| yout_ready | input | 2 | Per-channel ready, outgoing Y link |
| ej_valid | output | 1 | Local eject valid |
| ej_data | output | 16 | Local eject flit |
| ej_ready | input | 1 | Local eject ready |

## Verification
A corrupted per-input route latch, or a stale reservation on an output channel, shows up at the ports as a packet stalled forever or as a second head on a reserved channel. The stall is seen on the first flit that wants the stuck channel. The interleaved head is flagged in the cycle it is driven. A wrong dateline or turn decision changes which valid bit rises, and that shows one cycle after the head enters the FIFO. FIFO pointer faults show as reordered or lost flits, or as a ready that drops early. These faults appear as soon as the queue is filled and drained.

// File: rtl/torus_router_pkg.sv
// Shared constants for the torus router: flit layout and the numbering of
// input and output virtual channels. Assumes 16-bit flits whose two top bits
// carry the tail and head flags.
package torus_router_pkg;
    localparam int FLIT_W   = 16;
    localparam int TAIL_BIT = FLIT_W - 1;
    localparam int HEAD_BIT = FLIT_W - 2;

    // Channel numbering: 0/1 X link vc0/vc1, 2/3 Y link vc0/vc1, 4 local.
    localparam int NUM_CH   = 5;
    localparam int NUM_PORT = 3;
    localparam int P_X      = 0;
    localparam int P_Y      = 1;
    localparam int P_LOC    = 2;
    localparam int CH_W     = 3;

    // Physical port that carries a given channel index.
    function automatic logic [1:0] ch_port(input logic [CH_W-1:0] ch);
        return ch[2] ? 2'd2 : {1'b0, ch[1]};
    endfunction
endpackage

// File: rtl/torus_router_fifo.sv
// Flit queue for one input virtual channel.
// Assumes the caller never pushes when full and never pops when empty.
module torus_router_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [W-1:0]    mem_q [DEPTH];
    logic [AW-1:0]   rd_q, wr_q;
    logic [CNTW-1:0] cnt_q;

    // Storage write; the contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem_q[wr_q] <= din;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign dout  = mem_q[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNTW'(DEPTH));
endmodule

// File: rtl/torus_router_route.sv
// Dimension-order route and channel selection for one input channel.
// X is resolved first. Channel 1 is taken on the wrap hop of a ring.
// A turn or an injection restarts on channel 0.
// Assumes the torus links run toward increasing coordinates.
module torus_router_route
    import torus_router_pkg::*;
#(
    parameter int NX      = 4,
    parameter int NY      = 4,
    parameter int CW      = 2,
    parameter int IN_PORT = P_LOC,
    parameter int IN_VC   = 0
) (
    input  logic [2*CW-1:0] dest,
    input  logic [CW-1:0]   node_x,
    input  logic [CW-1:0]   node_y,
    output logic [CH_W-1:0] out_ch
);
    localparam logic ARRIVE_VC = 1'(IN_VC);

    logic [CW-1:0] dst_x, dst_y;
    logic          vc;

    assign dst_x = dest[2*CW-1:CW];
    assign dst_y = dest[CW-1:0];

    // Choose output port and virtual channel.
    always_comb begin
        vc = 1'b0;
        if (dst_x != node_x) begin
            vc     = (node_x == CW'(NX - 1)) ? 1'b1 : ((IN_PORT == P_X) ? ARRIVE_VC : 1'b0);
            out_ch = {2'b00, vc};
        end else if (dst_y != node_y) begin
            vc     = (node_y == CW'(NY - 1)) ? 1'b1 : ((IN_PORT == P_Y) ? ARRIVE_VC : 1'b0);
            out_ch = {2'b01, vc};
        end else begin
            out_ch = 3'd4;
        end
    end
endmodule

// File: rtl/torus_router_rr.sv
// Round-robin arbiter. The search starts one past the last winner.
// Assumes requests may change every cycle.
module torus_router_rr #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr_q, win;
    logic          any;
    int            idx;

    // Find the first request at or after the pointer.
    always_comb begin
        gnt = '0;
        win = ptr_q;
        any = 1'b0;
        idx = 0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr_q) + k) % N;
            if (!any && req[idx]) begin
                gnt[idx] = 1'b1;
                win      = IW'(idx);
                any      = 1'b1;
            end
        end
    end

    // Move the pointer past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n)   ptr_q <= '0;
        else if (any) ptr_q <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
    end
endmodule

// File: rtl/torus_router.sv
// Torus node router with wormhole switching and two virtual channels per
// ring link. Inputs: X link, Y link, local inject. Outputs: X link, Y link,
// local eject. Assumptions:
//  - A sender raises at most one channel valid per link per cycle.
//  - node_x and node_y stay constant while traffic flows.
// An output valid depends on that output's ready in the same cycle. Input
// readies come from registered FIFO state, so chained routers form no
// combinational loop.
module torus_router
    import torus_router_pkg::*;
#(
    parameter int NX    = 4,
    parameter int NY    = 4,
    parameter int CW    = $clog2((NX > NY) ? NX : NY),
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     node_x,
    input  logic [CW-1:0]     node_y,
    input  logic [1:0]        xin_valid,
    input  logic [FLIT_W-1:0] xin_data,
    output logic [1:0]        xin_ready,
    input  logic [1:0]        yin_valid,
    input  logic [FLIT_W-1:0] yin_data,
    output logic [1:0]        yin_ready,
    input  logic              inj_valid,
    input  logic [FLIT_W-1:0] inj_data,
    output logic              inj_ready,
    output logic [1:0]        xout_valid,
    output logic [FLIT_W-1:0] xout_data,
    input  logic [1:0]        xout_ready,
    output logic [1:0]        yout_valid,
    output logic [FLIT_W-1:0] yout_data,
    input  logic [1:0]        yout_ready,
    output logic              ej_valid,
    output logic [FLIT_W-1:0] ej_data,
    input  logic              ej_ready
);
    logic [NUM_CH-1:0] in_valid_v, ch_push, ch_pop, ch_empty, ch_full;
    logic [FLIT_W-1:0] ch_din   [NUM_CH];
    logic [FLIT_W-1:0] ch_front [NUM_CH];
    logic [CH_W-1:0]   head_ch  [NUM_CH];
    logic [CH_W-1:0]   want_ch  [NUM_CH];
    logic [CH_W-1:0]   held_ch_q[NUM_CH];
    logic [NUM_CH-1:0] held_q, want;
    logic [NUM_CH-1:0] out_busy, out_ready_v, out_valid_v;
    logic [NUM_CH-1:0] port_req [NUM_PORT];
    logic [NUM_CH-1:0] port_gnt [NUM_PORT];
    logic [FLIT_W-1:0] port_data[NUM_PORT];

    assign in_valid_v  = {inj_valid, yin_valid, xin_valid};
    assign out_ready_v = {ej_ready, yout_ready, xout_ready};
    assign ch_din[0] = xin_data;
    assign ch_din[1] = xin_data;
    assign ch_din[2] = yin_data;
    assign ch_din[3] = yin_data;
    assign ch_din[4] = inj_data;
    assign ch_push   = in_valid_v & ~ch_full;

    assign xin_ready = ~ch_full[1:0];
    assign yin_ready = ~ch_full[3:2];
    assign inj_ready = ~ch_full[4];

    // One queue, one route unit and one path latch per input channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_in
        torus_router_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) fifo_i (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (ch_push[i]),
            .din   (ch_din[i]),
            .pop   (ch_pop[i]),
            .dout  (ch_front[i]),
            .empty (ch_empty[i]),
            .full  (ch_full[i])
        );

        torus_router_route #(
            .NX(NX), .NY(NY), .CW(CW),
            .IN_PORT((i < 4) ? (i / 2) : P_LOC),
            .IN_VC  ((i < 4) ? (i % 2) : 0)
        ) route_i (
            .dest   (ch_front[i][2*CW-1:0]),
            .node_x (node_x),
            .node_y (node_y),
            .out_ch (head_ch[i])
        );

        // Hold the path from a sent head until its tail is sent.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_q[i]    <= 1'b0;
                held_ch_q[i] <= '0;
            end else if (ch_pop[i]) begin
                if (ch_front[i][TAIL_BIT]) begin
                    held_q[i] <= 1'b0;
                end else if (ch_front[i][HEAD_BIT]) begin
                    held_q[i]    <= 1'b1;
                    held_ch_q[i] <= head_ch[i];
                end
            end
        end
    end

    // Output channels reserved by packets still in flight.
    always_comb begin
        out_busy = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (held_q[i]) out_busy[held_ch_q[i]] = 1'b1;
    end

    // Each input's request: a held path, or a head aimed at a free channel.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            want_ch[i] = held_q[i] ? held_ch_q[i] : head_ch[i];
            want[i]    = !ch_empty[i] && out_ready_v[want_ch[i]] &&
                         (held_q[i] || (ch_front[i][HEAD_BIT] && !out_busy[head_ch[i]]));
        end
    end

    // Sort the requests by physical output port.
    always_comb begin
        for (int p = 0; p < NUM_PORT; p++)
            for (int i = 0; i < NUM_CH; i++)
                port_req[p][i] = want[i] && (ch_port(want_ch[i]) == 2'(p));
    end

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_arb
        torus_router_rr #(.N(NUM_CH)) arb_i (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (port_req[p]),
            .gnt   (port_gnt[p])
        );
    end

    // Switch: pop the winners and drive each port's data and channel valid.
    always_comb begin
        ch_pop      = '0;
        out_valid_v = '0;
        for (int p = 0; p < NUM_PORT; p++) begin
            port_data[p] = '0;
            ch_pop       = ch_pop | port_gnt[p];
            for (int i = 0; i < NUM_CH; i++) begin
                if (port_gnt[p][i]) begin
                    port_data[p]            = ch_front[i];
                    out_valid_v[want_ch[i]] = 1'b1;
                end
            end
        end
    end

    assign xout_valid = out_valid_v[1:0];
    assign yout_valid = out_valid_v[3:2];
    assign ej_valid   = out_valid_v[4];
    assign xout_data  = port_data[P_X];
    assign yout_data  = port_data[P_Y];
    assign ej_data    = port_data[P_LOC];
endmodule

// File: rtl/torus_router_chk.sv
// Port-level protocol checker for torus_router. It is bound to every
// instance. It watches only the outputs and the coordinate straps.
module torus_router_chk
    import torus_router_pkg::*;
#(
    parameter int CW = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CW-1:0]     node_x,
    input logic [CW-1:0]     node_y,
    input logic [1:0]        xout_valid,
    input logic [FLIT_W-1:0] xout_data,
    input logic [1:0]        xout_ready,
    input logic [1:0]        yout_valid,
    input logic [FLIT_W-1:0] yout_data,
    input logic [1:0]        yout_ready,
    input logic              ej_valid,
    input logic [FLIT_W-1:0] ej_data,
    input logic              ej_ready
);
    logic [NUM_CH-1:0] ov;
    logic [FLIT_W-1:0] od [NUM_CH];
    logic [NUM_CH-1:0] open_q;

    assign ov    = {ej_valid, yout_valid, xout_valid};
    assign od[0] = xout_data;
    assign od[1] = xout_data;
    assign od[2] = yout_data;
    assign od[3] = yout_data;
    assign od[4] = ej_data;

    // Track output channels that are in the middle of a packet.
    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= '0;
        else begin
            for (int o = 0; o < NUM_CH; o++) begin
                if (ov[o] && od[o][TAIL_BIT])      open_q[o] <= 1'b0;
                else if (ov[o] && od[o][HEAD_BIT]) open_q[o] <= 1'b1;
            end
        end
    end

    AST_ONE_VC_X: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(xout_valid)); // R11
    AST_ONE_VC_Y: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(yout_valid)); // R11
    AST_VALID_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((xout_valid & ~xout_ready) == 2'b00) && ((yout_valid & ~yout_ready) == 2'b00) && !(ej_valid && !ej_ready)); // R8
    AST_EJECT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (ej_valid && ej_data[HEAD_BIT]) |-> (ej_data[2*CW-1:0] == {node_x, node_y})); // R1

    for (genvar o = 0; o < NUM_CH; o++) begin : g_lock
        AST_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (!rst_n)
            (ov[o] && open_q[o]) |-> !od[o][HEAD_BIT]); // R6
    end
endmodule

bind torus_router torus_router_chk #(.CW(CW)) chk_i (.*);

// File: tb/torus_router_tb_top.sv
`timescale 1ns/1ps
module torus_router_tb_top;
    localparam int CW = 2;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [CW-1:0] node_x = '0, node_y = '0;
    logic [1:0]  xin_valid = '0, yin_valid = '0, xin_ready, yin_ready;
    logic [15:0] xin_data = '0, yin_data = '0, inj_data = '0;
    logic        inj_valid = 1'b0, inj_ready;
    logic [1:0]  xout_valid, yout_valid;
    logic [1:0]  xout_ready = 2'b11, yout_ready = 2'b11;
    logic [15:0] xout_data, yout_data, ej_data;
    logic        ej_valid, ej_ready = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    torus_router #(.NX(4), .NY(4), .DEPTH(DEPTH)) dut_i (.*);

    // Each entry packs {node x, node y, source channel, dest x, dest y,
    // expected output channel}.
    // Source and output channels: 0/1 X vc0/vc1, 2/3 Y vc0/vc1, 4 local.
    localparam int NV = 13;
    localparam logic [13:0] VEC [NV] = '{
        {2'd1, 2'd1, 3'd4, 2'd1, 2'd1, 3'd4},
        {2'd1, 2'd1, 3'd4, 2'd3, 2'd0, 3'd0},
        {2'd3, 2'd1, 3'd4, 2'd1, 2'd1, 3'd1},
        {2'd1, 2'd1, 3'd0, 2'd2, 2'd2, 3'd0},
        {2'd3, 2'd2, 3'd0, 2'd0, 2'd2, 3'd1},
        {2'd0, 2'd2, 3'd1, 2'd2, 2'd2, 3'd1},
        {2'd2, 2'd1, 3'd1, 2'd2, 2'd3, 3'd2},
        {2'd2, 2'd3, 3'd0, 2'd2, 2'd0, 3'd3},
        {2'd2, 2'd1, 3'd3, 2'd2, 2'd3, 3'd3},
        {2'd2, 2'd3, 3'd2, 2'd2, 2'd1, 3'd3},
        {2'd2, 2'd2, 3'd3, 2'd2, 2'd2, 3'd4},
        {2'd0, 2'd0, 3'd4, 2'd0, 2'd2, 3'd2},
        {2'd1, 2'd1, 3'd0, 2'd1, 2'd1, 3'd4}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        xin_valid = '0; yin_valid = '0; inj_valid = 1'b0;
    endtask

    task automatic send(input int src, input logic [15:0] d);
        case (src)
            0: begin xin_valid = 2'b01; xin_data = d; end
            1: begin xin_valid = 2'b10; xin_data = d; end
            2: begin yin_valid = 2'b01; yin_data = d; end
            3: begin yin_valid = 2'b10; yin_data = d; end
            default: begin inj_valid = 1'b1; inj_data = d; end
        endcase
    endtask

    function automatic logic [4:0] all_valid();
        return {ej_valid, yout_valid, xout_valid};
    endfunction

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] a_head, a_body, a_tail, b_one, got;
        logic [2:0]  seen;

        // Reset state (R10).
        repeat (3) @(negedge clk);
        chk(all_valid() == 5'b0, "R10 valid in reset", 32'(all_valid()), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({inj_ready, yin_ready, xin_ready} == 5'h1f && all_valid() == 5'b0,
            "R10 after reset", {inj_ready, yin_ready, xin_ready, all_valid()}, 32'h3e0);

        // Routing table walk (R1 R2 R3 R4 R5).
        for (int k = 0; k < NV; k++) begin
            logic [13:0] v;
            logic [15:0] f;
            logic [4:0]  exp_v;
            v = VEC[k];
            node_x = v[13:12];
            node_y = v[11:10];
            f = {2'b11, 6'(k), 4'h0, v[6:5], v[4:3]};
            send(int'(v[9:7]), f);
            @(negedge clk);
            clear_in();
            exp_v = 5'b1 << v[2:0];
            got = (v[2:0] == 3'd4) ? ej_data : (v[2:1] == 2'd1) ? yout_data : xout_data;
            chk(all_valid() == exp_v && got == f, "R1 R2 R3 R4 R5 route",
                {11'b0, all_valid(), got}, {11'b0, exp_v, f});
            @(negedge clk);
        end

        // Wormhole reservation (R6): node (2,1), both packets want Y vc0.
        node_x = 2'd2; node_y = 2'd1;
        a_head = {2'b01, 6'h0a, 4'h0, 2'd2, 2'd3};
        a_body = {2'b00, 6'h1a, 4'h0, 2'd0, 2'd0};
        a_tail = {2'b10, 6'h2a, 4'h0, 2'd0, 2'd0};
        b_one  = {2'b11, 6'h0b, 4'h0, 2'd2, 2'd3};
        send(0, a_head);
        @(negedge clk);
        chk(yout_valid == 2'b01 && yout_data == a_head, "R6 R5 head turn", {yout_valid, yout_data}, {2'b01, a_head});
        clear_in(); send(4, b_one);
        @(negedge clk);
        chk(yout_valid == 2'b00, "R6 other head blocked", 32'(yout_valid), 0);
        clear_in(); send(0, a_body);
        @(negedge clk);
        chk(yout_valid == 2'b01 && yout_data == a_body, "R6 body follows", {yout_valid, yout_data}, {2'b01, a_body});
        clear_in(); send(0, a_tail);
        @(negedge clk);
        chk(yout_valid == 2'b01 && yout_data == a_tail, "R6 tail follows", {yout_valid, yout_data}, {2'b01, a_tail});
        clear_in();
        @(negedge clk);
        chk(yout_valid == 2'b01 && yout_data == b_one, "R6 released after tail", {yout_valid, yout_data}, {2'b01, b_one});
        @(negedge clk);

        // Contention with backpressure (R8 R7 R11).
        yout_ready = 2'b00;
        send(0, {2'b11, 6'd0, 4'h0, 2'd2, 2'd3});
        send(4, {2'b11, 6'd1, 4'h0, 2'd2, 2'd3});
        send(3, {2'b11, 6'd2, 4'h0, 2'd2, 2'd3});
        @(negedge clk);
        clear_in();
        chk(all_valid() == 5'b0, "R8 nothing while not ready", 32'(all_valid()), 0);
        @(negedge clk);
        chk(all_valid() == 5'b0, "R8 still held", 32'(all_valid()), 0);
        yout_ready = 2'b11;
        seen = '0;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk($countones(yout_valid) == 1, "R7 R11 one flit per cycle", 32'(yout_valid), 1);
            if (yout_data[13:8] < 6'd3) seen[yout_data[9:8]] = 1'b1;
            @(negedge clk);
        end
        chk(seen == 3'b111, "R7 every contender served", 32'(seen), 7);
        #1;
        chk(all_valid() == 5'b0, "R7 queue drained", 32'(all_valid()), 0);
        @(negedge clk);

        // FIFO depth, drop when full, order (R9 R8).
        node_x = 2'd1; node_y = 2'd1;
        ej_ready = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            send(4, {2'b11, 6'(k), 4'h0, 2'd1, 2'd1});
            @(negedge clk);
        end
        chk(inj_ready == 1'b0, "R9 ready low when full", 32'(inj_ready), 0);
        send(4, {2'b11, 6'h3f, 4'h0, 2'd1, 2'd1});
        @(negedge clk);
        clear_in();
        chk(ej_valid == 1'b0, "R8 eject waits for ready", 32'(ej_valid), 0);
        ej_ready = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            #1;
            chk(ej_valid && ej_data[13:8] == 6'(k), "R9 order kept", {ej_valid, ej_data}, {1'b1, 2'b11, 6'(k), 8'h05});
            @(negedge clk);
        end
        #1;
        chk(ej_valid == 1'b0 && inj_ready == 1'b1, "R9 flit offered when full dropped", {ej_valid, inj_ready}, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule